// File: doc/BRIEF.md
# Multi-Accumulator Operand Register Selector

This block picks operand registers for a processor of the small 8-bit family that has been widened to 16-bit opcodes and has sixteen general accumulators instead of a single one. The low byte of each opcode names the base instruction class. The high byte carries two 4-bit register fields. The destination index sits in bits 15:12 and the source index in bits 11:8. Index 0 is accumulator A, so an opcode whose high byte is 0x00 acts exactly like the single-accumulator original.

The block holds the sixteen 16-bit accumulators. It has one combinational read port, which returns the source operand, and one clocked write port. For each valid instruction it reports four things: whether the source is read, whether and where the destination is written, whether the N/Z flags should update, and whether the register selection is illegal. The result to be written comes in on `wb_data` from the execution logic, which sits outside the block. Any base byte or field combination that the decode does not cover falls into a default branch. That branch raises `illegal` and blocks the write.

Top module: `acc_sel_top`

## Requirements
- R1: `src_idx` equals opcode bits 11:8, `dst_idx` equals opcode bits 15:12, and `src_data` shows the current content of the register named by `src_idx` in the same cycle, with no clock delay.
- R2: A base byte whose low nibble is 0x9 (arithmetic/logic class) is legal for all 256 source/destination pairs. It sets `src_rd`, `dst_we` and `nz_upd`.
- R3: A base byte whose low nibble is 0xA is a shift/rotate. The shift amount is base bits 7:4 and appears on `shift_amt`. It is legal only when the amount is 1 to 15 and both indices are 0 to 3. Otherwise `illegal` is set and no register is written.
- R4: Load (0xAD) and pull (0x68) write the destination and need the source field to be 0. Store (0x8D) and push (0x48) read the source without writing, and need the destination field to be 0. Compare (0xCD) reads the source, sets `nz_upd`, writes nothing, and needs the destination field to be 0. A nonzero value in the unused field is illegal.
- R5: Accumulator increment (0xEE) and decrement (0xCE) are legal only when source equals destination. They then read, write and set `nz_upd`. Otherwise they are illegal.
- R6: Index-register increments (0xE8, 0xC8, 0xCB) touch no accumulator: `src_rd` and `dst_we` are 0. They are legal only with a high byte of 0x00.
- R7: Transfer (0x8B) copies from the source to the destination. When source and destination are the same register, the write still happens and `nz_upd` is set.
- R8: Any other base byte is illegal. Whenever `illegal` is 1, both `dst_we` and `nz_upd` are 0 and the register file does not change.
- R9: A register is updated with `wb_data` on the rising clock edge when `dst_we` is 1. A synchronous reset clears all sixteen registers to 0.
- R10: While `instr_valid` is 0, `src_rd`, `dst_we`, `nz_upd` and `illegal` are 0 and no register changes.
- R11: With a high byte of 0x00, an arithmetic/logic opcode reads and writes accumulator A (index 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Opcode on `opcode` is live this cycle |
| opcode | input | 16 | Destination index, source index, base byte |
| wb_data | input | 16 | Result to write to the destination |
| src_data | output | 16 | Content of the source register |
| src_idx | output | 4 | Source register index |
| dst_idx | output | 4 | Destination register index |
| src_rd | output | 1 | Source operand is used |
| dst_we | output | 1 | Destination write this cycle |
| nz_upd | output | 1 | N/Z flags take the result |
| illegal | output | 1 | Undecoded opcode or forbidden selection |
| shift_amt | output | 4 | Shift/rotate count |

## Verification
Several checks run on every cycle: a trapped opcode never writes or updates flags, an idle cycle stays quiet, a shift never writes above register D, an increment or decrement writes only into its own source, and a write lands in the chosen register at the next edge. Only the directed scenarios can show the class-by-class legality table. This includes which fixed field each class needs, that the read path returns the correct register, that a same-register transfer really updates, and that the reset clears the whole file.

// File: rtl/acc_sel_pkg.sv
package acc_sel_pkg;

    typedef enum logic [3:0] {
        CL_ALU,
        CL_SHIFT,
        CL_XFER,
        CL_LOAD,
        CL_STORE,
        CL_CMP,
        CL_INCDEC,
        CL_IDXINC,
        CL_PUSH,
        CL_PULL,
        CL_NONE
    } op_class_e;

    typedef struct packed {
        logic rd;
        logic we;
        logic nz;
        logic illegal;
    } sel_ctl_t;

endpackage

// File: rtl/acc_base_class.sv
module acc_base_class
    import acc_sel_pkg::*;
#(
    parameter int BASE_W = 8,
    localparam int AMT_W = BASE_W - 4
) (
    input  logic [BASE_W-1:0] base,
    output op_class_e         cls,
    output logic [AMT_W-1:0]  amt
);

    always_comb begin
        amt = base[BASE_W-1:4];
        cls = CL_NONE;
        if (base[3:0] == 4'h9) begin
            cls = CL_ALU;
        end else if (base[3:0] == 4'hA) begin
            cls = CL_SHIFT;
        end else begin
            case (base)
                BASE_W'(8'h8B): cls = CL_XFER;
                BASE_W'(8'hAD): cls = CL_LOAD;
                BASE_W'(8'h8D): cls = CL_STORE;
                BASE_W'(8'hCD): cls = CL_CMP;
                BASE_W'(8'hEE),
                BASE_W'(8'hCE): cls = CL_INCDEC;
                BASE_W'(8'hE8),
                BASE_W'(8'hC8),
                BASE_W'(8'hCB): cls = CL_IDXINC;
                BASE_W'(8'h48): cls = CL_PUSH;
                BASE_W'(8'h68): cls = CL_PULL;
                default:        cls = CL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/acc_field_check.sv
module acc_field_check
    import acc_sel_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int AMT_W      = 4,
    parameter int SHIFT_REGS = 4
) (
    input  logic             valid,
    input  op_class_e        cls,
    input  logic [AMT_W-1:0] amt,
    input  logic [IDX_W-1:0] dst_f,
    input  logic [IDX_W-1:0] src_f,
    output sel_ctl_t         ctl
);

    localparam logic [IDX_W:0] SH_LIM = (IDX_W+1)'(SHIFT_REGS);

    logic zero_src, zero_dst, same, sub_ok;

    always_comb begin
        zero_src = (src_f == '0);
        zero_dst = (dst_f == '0);
        same     = (src_f == dst_f);
        sub_ok   = ({1'b0, dst_f} < SH_LIM) && ({1'b0, src_f} < SH_LIM);

        ctl = '0;
        case (cls)
            CL_ALU, CL_XFER: begin
                ctl.rd = 1'b1; ctl.we = 1'b1; ctl.nz = 1'b1;
            end
            CL_SHIFT: begin
                if ((amt != '0) && sub_ok) begin
                    ctl.rd = 1'b1; ctl.we = 1'b1; ctl.nz = 1'b1;
                end else begin
                    ctl.illegal = 1'b1;
                end
            end
            CL_LOAD, CL_PULL: begin
                if (zero_src) begin
                    ctl.we = 1'b1; ctl.nz = 1'b1;
                end else begin
                    ctl.illegal = 1'b1;
                end
            end
            CL_STORE, CL_PUSH: begin
                if (zero_dst) ctl.rd = 1'b1;
                else          ctl.illegal = 1'b1;
            end
            CL_CMP: begin
                if (zero_dst) begin
                    ctl.rd = 1'b1; ctl.nz = 1'b1;
                end else begin
                    ctl.illegal = 1'b1;
                end
            end
            CL_INCDEC: begin
                if (same) begin
                    ctl.rd = 1'b1; ctl.we = 1'b1; ctl.nz = 1'b1;
                end else begin
                    ctl.illegal = 1'b1;
                end
            end
            CL_IDXINC: begin
                if (!(zero_src && zero_dst)) ctl.illegal = 1'b1;
            end
            default: ctl.illegal = 1'b1;
        endcase

        if (!valid) ctl = '0;
    end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int NREG   = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] mem;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.mem = '0;
        end else if (wr_en) begin
            st_d.mem[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_data = st_q.mem[rd_idx];

    // R9: a granted write is visible at the next edge
    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (st_q.mem[$past(wr_idx)] == $past(wr_data)));

    // R9: synchronous reset empties the whole file
    p_reset_clears_r9: assert property (@(posedge clk)
        rst |=> (st_q.mem == '0));

endmodule

// File: rtl/acc_sel_top.sv
module acc_sel_top
    import acc_sel_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int DATA_W     = 16,
    parameter int BASE_W     = 8,
    parameter int SHIFT_REGS = 4,
    localparam int IDX_W     = $clog2(NREG),
    localparam int OPC_W     = BASE_W + 2 * IDX_W,
    localparam int AMT_W     = BASE_W - 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] wb_data,
    output logic [DATA_W-1:0] src_data,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              src_rd,
    output logic              dst_we,
    output logic              nz_upd,
    output logic              illegal,
    output logic [AMT_W-1:0]  shift_amt
);

    op_class_e cls;
    sel_ctl_t  ctl;

    assign dst_idx = opcode[OPC_W-1 -: IDX_W];
    assign src_idx = opcode[BASE_W +: IDX_W];

    acc_base_class #(.BASE_W(BASE_W)) u_class (
        .base (opcode[BASE_W-1:0]),
        .cls  (cls),
        .amt  (shift_amt)
    );

    acc_field_check #(
        .IDX_W(IDX_W), .AMT_W(AMT_W), .SHIFT_REGS(SHIFT_REGS)
    ) u_check (
        .valid (instr_valid),
        .cls   (cls),
        .amt   (shift_amt),
        .dst_f (dst_idx),
        .src_f (src_idx),
        .ctl   (ctl)
    );

    assign src_rd  = ctl.rd;
    assign dst_we  = ctl.we;
    assign nz_upd  = ctl.nz;
    assign illegal = ctl.illegal;

    acc_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dst_we),
        .wr_idx  (dst_idx),
        .wr_data (wb_data),
        .rd_idx  (src_idx),
        .rd_data (src_data)
    );

    localparam logic [IDX_W:0] SH_LIM = (IDX_W+1)'(SHIFT_REGS);

    // R8: a trapped opcode never writes nor touches flags
    p_trap_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!dst_we && !nz_upd));

    // R10: idle cycle produces no strobes
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (!dst_we && !nz_upd && !illegal && !src_rd));

    // R3: shift writes stay inside the low register subset
    p_shift_subset_r3: assert property (@(posedge clk) disable iff (rst)
        (dst_we && opcode[3:0] == 4'hA) |->
            (({1'b0, dst_idx} < SH_LIM) && ({1'b0, src_idx} < SH_LIM)));

    // R5: increment/decrement writes only into its own source
    p_incdec_self_r5: assert property (@(posedge clk) disable iff (rst)
        (dst_we && (opcode[BASE_W-1:0] == BASE_W'(8'hEE) ||
                    opcode[BASE_W-1:0] == BASE_W'(8'hCE))) |->
            (dst_idx == src_idx));

endmodule

// File: tb/acc_sel_top_bench.sv
module acc_sel_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] wb_data = '0;
    logic [15:0] src_data;
    logic [3:0]  src_idx, dst_idx, shift_amt;
    logic        src_rd, dst_we, nz_upd, illegal;

    int total = 0;
    int bad = 0;
    logic [15:0] model [16];

    logic [15:0] c_src;
    logic [3:0]  c_amt, c_didx;
    logic        c_rd, c_we, c_nz, c_ill;

    always #2 clk = ~clk;

    acc_sel_top u_acc_sel_top (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
        .wb_data(wb_data), .src_data(src_data), .src_idx(src_idx),
        .dst_idx(dst_idx), .src_rd(src_rd), .dst_we(dst_we),
        .nz_upd(nz_upd), .illegal(illegal), .shift_amt(shift_amt)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one opcode, capture outputs, then clock it in
    task automatic run_op(input logic [15:0] op, input logic [15:0] d, input logic v);
        @(negedge clk);
        opcode = op; wb_data = d; instr_valid = v;
        #1;
        c_src = src_data; c_amt = shift_amt; c_didx = dst_idx;
        c_rd = src_rd; c_we = dst_we; c_nz = nz_upd; c_ill = illegal;
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
    endtask

    task automatic peek(input logic [3:0] idx, output logic [15:0] val);
        @(negedge clk);
        opcode = {4'h0, idx, 8'h8D}; instr_valid = 1'b1;
        #1;
        val = src_data;
        instr_valid = 1'b0;
    endtask

    task automatic check_file(input string req);
        logic [15:0] v;
        for (int i = 0; i < 16; i++) begin
            peek(4'(i), v);
            chk(v == model[i], req, {16'h0, v}, {16'h0, model[i]});
        end
    endtask

    task automatic t_reset_state;
        for (int i = 0; i < 16; i++) model[i] = '0;
        check_file("R9 reset clear");
    endtask

    task automatic t_load_all;
        for (int i = 0; i < 16; i++) begin
            logic [15:0] d;
            d = 16'hA000 + 16'(i) * 16'h0111;
            run_op({4'(i), 4'h0, 8'hAD}, d, 1'b1);
            chk(c_we && c_nz && !c_ill && !c_rd, "R4 load legal",
                {28'h0, c_we, c_nz, c_ill, c_rd}, 32'hC);
            model[i] = d;
        end
        check_file("R9 load writes");
    endtask

    task automatic t_alu;
        logic [15:0] v;
        run_op({4'h3, 4'h5, 8'h69}, 16'hBEEF, 1'b1);
        chk(c_src == model[5], "R1 src read", {16'h0, c_src}, {16'h0, model[5]});
        chk(c_didx == 4'h3, "R1 dst index", {28'h0, c_didx}, 32'h3);
        chk(c_rd && c_we && c_nz && !c_ill, "R2 alu strobes",
            {28'h0, c_rd, c_we, c_nz, c_ill}, 32'hE);
        model[3] = 16'hBEEF;
        peek(4'h3, v);
        chk(v == 16'hBEEF, "R9 alu result", {16'h0, v}, 32'hBEEF);
        run_op({4'h0, 4'hF, 8'hE9}, 16'h1234, 1'b1);
        chk(c_we && !c_ill && c_src == model[15], "R2 pair F to 0",
            {15'h0, c_we, c_src}, {15'h0, 1'b1, model[15]});
        model[0] = 16'h1234;
        run_op({8'h00, 8'h29}, 16'h4321, 1'b1);
        chk(c_src == 16'h1234 && c_didx == 4'h0 && c_we, "R11 page zero uses A",
            {12'h0, c_didx, c_src}, {12'h0, 4'h0, 16'h1234});
        model[0] = 16'h4321;
        check_file("R1 file after alu");
    endtask

    task automatic t_shift;
        run_op({4'h2, 4'h1, 8'h3A}, 16'h0F0F, 1'b1);
        chk(c_we && !c_ill && c_amt == 4'h3 && c_src == model[1], "R3 shift legal",
            {11'h0, c_we, c_ill, c_amt, c_src}, {11'h0, 1'b1, 1'b0, 4'h3, model[1]});
        model[2] = 16'h0F0F;
        run_op({4'h4, 4'h1, 8'h3A}, 16'hDEAD, 1'b1);
        chk(c_ill && !c_we && !c_nz, "R3 shift dst above D",
            {29'h0, c_ill, c_we, c_nz}, 32'h4);
        run_op({4'h1, 4'h7, 8'h5A}, 16'hDEAD, 1'b1);
        chk(c_ill && !c_we, "R3 shift src above D", {30'h0, c_ill, c_we}, 32'h2);
        run_op({4'h1, 4'h2, 8'h0A}, 16'hDEAD, 1'b1);
        chk(c_ill && !c_we && c_amt == 4'h0, "R3 shift amount zero",
            {26'h0, c_ill, c_we, c_amt}, 32'h20);
        check_file("R3 file after shifts");
    endtask

    task automatic t_fixed_fields;
        run_op({4'h2, 4'h1, 8'hAD}, 16'hDEAD, 1'b1);
        chk(c_ill && !c_we, "R4 load src nonzero", {30'h0, c_ill, c_we}, 32'h2);
        run_op({4'h1, 4'h6, 8'h8D}, 16'hDEAD, 1'b1);
        chk(c_ill && !c_rd, "R4 store dst nonzero", {30'h0, c_ill, c_rd}, 32'h2);
        run_op({4'h0, 4'h6, 8'h48}, 16'hDEAD, 1'b1);
        chk(c_rd && !c_we && !c_ill && c_src == model[6], "R4 push reads",
            {13'h0, c_rd, c_we, c_ill, c_src}, {13'h0, 3'b100, model[6]});
        run_op({4'h0, 4'h9, 8'hCD}, 16'hDEAD, 1'b1);
        chk(c_rd && c_nz && !c_we && !c_ill, "R4 compare",
            {28'h0, c_rd, c_nz, c_we, c_ill}, 32'hC);
        run_op({4'h8, 4'h0, 8'h68}, 16'h5A5A, 1'b1);
        chk(c_we && !c_ill, "R4 pull", {30'h0, c_we, c_ill}, 32'h2);
        model[8] = 16'h5A5A;
        check_file("R4 file after fixed fields");
    endtask

    task automatic t_incdec;
        run_op({4'h6, 4'h6, 8'hEE}, model[6] + 16'h1, 1'b1);
        chk(c_we && c_nz && !c_ill, "R5 inc same reg", {29'h0, c_we, c_nz, c_ill}, 32'h6);
        model[6] = model[6] + 16'h1;
        run_op({4'h6, 4'h7, 8'hCE}, 16'hDEAD, 1'b1);
        chk(c_ill && !c_we, "R5 dec split regs", {30'h0, c_ill, c_we}, 32'h2);
        check_file("R5 file after incdec");
    endtask

    task automatic t_index;
        run_op({8'h00, 8'hE8}, 16'hDEAD, 1'b1);
        chk(!c_ill && !c_we && !c_rd, "R6 index inc", {29'h0, c_ill, c_we, c_rd}, 32'h0);
        run_op({8'h00, 8'hCB}, 16'hDEAD, 1'b1);
        chk(!c_ill && !c_we, "R6 third index inc", {30'h0, c_ill, c_we}, 32'h0);
        run_op({8'h10, 8'hC8}, 16'hDEAD, 1'b1);
        chk(c_ill && !c_we, "R6 index with high byte", {30'h0, c_ill, c_we}, 32'h2);
        check_file("R6 file after index ops");
    endtask

    task automatic t_transfer;
        run_op({4'hC, 4'h5, 8'h8B}, model[5], 1'b1);
        chk(c_we && c_src == model[5], "R7 transfer", {15'h0, c_we, c_src}, {15'h0, 1'b1, model[5]});
        model[12] = model[5];
        run_op({4'h7, 4'h7, 8'h8B}, 16'h7777, 1'b1);
        chk(c_we && c_nz && !c_ill, "R7 same reg transfer", {29'h0, c_we, c_nz, c_ill}, 32'h6);
        model[7] = 16'h7777;
        check_file("R7 file after transfers");
    endtask

    task automatic t_undefined;
        run_op({4'h1, 4'h2, 8'hFF}, 16'hDEAD, 1'b1);
        chk(c_ill && !c_we && !c_nz, "R8 undefined base", {29'h0, c_ill, c_we, c_nz}, 32'h4);
        run_op({4'h3, 4'h0, 8'h00}, 16'hDEAD, 1'b1);
        chk(c_ill && !c_we, "R8 undefined zero base", {30'h0, c_ill, c_we}, 32'h2);
        check_file("R8 file untouched");
    endtask

    task automatic t_idle;
        run_op({4'h4, 4'h2, 8'h69}, 16'hDEAD, 1'b0);
        chk(!c_we && !c_nz && !c_ill && !c_rd, "R10 idle strobes",
            {28'h0, c_we, c_nz, c_ill, c_rd}, 32'h0);
        check_file("R10 file untouched");
    endtask

    task automatic t_midreset;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        check_file("R9 mid reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset_state();
        t_load_all();
        t_alu();
        t_shift();
        t_fixed_fields();
        t_incdec();
        t_index();
        t_transfer();
        t_undefined();
        t_idle();
        t_midreset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule